// File: doc/BRIEF.md
# Fan Tachometer Period Monitor

This block times the revolutions of several cooling fans. Each fan has a tachometer line that pulses once per turn. A per-fan 12-bit counter advances on a slow timebase pulse. On every rising tach edge, the count since the previous edge is captured as the fan's period result. A fan that stops lets its counter run up to the all-ones value, and the result then reports that value as "no valid speed". With a 25 kHz timebase, speed in rpm is 1,500,000 divided by the result. A result of 0 or 0xFFF means no usable speed.

Software reaches the block through an 8-bit index/data port. Each 12-bit quantity occupies two consecutive byte indices, high byte first. Reading a result's high byte freezes the matching low byte, so a high-then-low pair always describes one sample. A 12-bit low-speed limit is written high byte first. The write of the low byte commits both halves. A per-fan control byte can switch monitoring off. A fan alarm output is raised whenever an enabled fan's result is longer than its limit, which means the fan is turning too slowly.

Top module: `fan_tach_monitor`

## Requirements
- R1: After reset, every result reads 0, every limit reads 0xFFF (high byte 0x0F, low byte 0xFF), every control byte reads 0x00, every latched low byte reads 0 and no alarm is raised.
- R2: While a fan is enabled, its running count rises by one on each cycle with `tick` high. On a rising tach edge the running count is copied into the result and the counter restarts from 0. A tick in the edge cycle is not counted, so a period of P cycles with a tick every cycle yields P-1.
- R3: If no tach edge arrives, the running count stops at 0xFFF. One cycle later the result becomes 0xFFF, and it holds that value until the next edge.
- R4: The result of fan n is read at index 0x20+2n, giving {4'b0, result[11:8]}, and at index 0x21+2n. Read data is combinational from `reg_idx`, and the upper four bits of the high byte are always 0.
- R5: A read (`reg_rd` high) of index 0x20+2n stores result[7:0] in a latch at the clock edge. Index 0x21+2n always returns that latch, and the latch keeps its value when the result changes.
- R6: A write to 0x28+2n only stages wdata[3:0]. A write to 0x29+2n sets fan n's limit to {staged nibble, wdata}. The limit reads back as {4'b0, limit[11:8]} at 0x28+2n and limit[7:0] at 0x29+2n, and a high-byte write alone leaves the limit unchanged.
- R7: The control byte of fan n is read and written at index 0x60+16n. When its bit 7 is 1 the fan is disabled: its result is held at 0 and its alarm stays low.
- R8: `fan_alarm[n]` is high exactly when fan n is enabled and its result is strictly greater than its limit. An equal value does not alarm, and a limit of 0xFFF never alarms.
- R9: Writes to result indices and to unmapped indices change nothing, and unmapped indices read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timebase pulse, one cycle wide |
| tach_in | input | NUM_FANS | Tachometer lines, one per fan, already synchronous |
| reg_idx | input | 8 | Register index |
| reg_wr | input | 1 | Write strobe for `reg_wdata` at `reg_idx` |
| reg_rd | input | 1 | Read strobe; arms the low-byte latch on a result high-byte read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_idx` |
| fan_alarm | output | NUM_FANS | Per-fan low-speed alarm |

## Verification
Two pairs of events can fall in the same cycle. The first is a tach edge together with a timebase tick. The bench runs the timebase on every cycle while the fans toggle with fixed periods, so every capture coincides with a tick, and it judges the captured value against P-1. The second is a high-byte read together with a new capture. Back-to-back high/low reads of a fast fan place captures on or just before the read cycle. A behavioural model compares every read byte and every alarm on each clock, and a bound property ties the low-byte reply to the result seen during the preceding high-byte read.

// File: rtl/fan_tach_pkg.sv
package fan_tach_pkg;
    localparam int DATA_W        = 8;
    localparam int IDX_W         = 8;
    localparam int CNT_IDX_BASE  = 'h20;
    localparam int LIM_IDX_BASE  = 'h28;
    localparam int CTRL_IDX_BASE = 'h60;
    localparam int CTRL_STRIDE   = 16;
    localparam int OFF_BIT       = 7;
endpackage

// File: rtl/fan_tach_channel.sv
module fan_tach_channel #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             tach_i,
    input  logic             en_i,
    output logic [CNT_W-1:0] result_o
);
    localparam logic [CNT_W-1:0] SAT = '1;

    typedef struct packed {
        logic             prev;
        logic [CNT_W-1:0] run;
        logic [CNT_W-1:0] res;
    } chan_t;

    chan_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = tach_i;
        if (!en_i) begin
            st_d.run = '0;
            st_d.res = '0;
        end else if (tach_i && !st_q.prev) begin
            st_d.res = st_q.run;
            st_d.run = '0;
        end else begin
            if (st_q.run == SAT) st_d.res = SAT;
            if (tick_i && st_q.run != SAT) st_d.run = st_q.run + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result_o = st_q.res;
endmodule

// File: rtl/fan_tach_regs.sv
module fan_tach_regs
    import fan_tach_pkg::*;
#(
    parameter int NUM_FANS = 3,
    parameter int CNT_W    = 12
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [IDX_W-1:0]                 idx_i,
    input  logic                             wr_i,
    input  logic                             rd_i,
    input  logic [DATA_W-1:0]                wdata_i,
    input  logic [NUM_FANS-1:0][CNT_W-1:0]   results_i,
    output logic [DATA_W-1:0]                rdata_o,
    output logic [NUM_FANS-1:0][CNT_W-1:0]   limits_o,
    output logic [NUM_FANS-1:0]              en_o
);
    localparam int WIDE_W = 2 * DATA_W;
    localparam int STG_W  = CNT_W - DATA_W;

    typedef struct packed {
        logic [NUM_FANS-1:0][CNT_W-1:0]  limit;
        logic [NUM_FANS-1:0][DATA_W-1:0] ctrl;
        logic [NUM_FANS-1:0][DATA_W-1:0] latch;
        logic [STG_W-1:0]                stage;
    } regs_t;

    regs_t rg_d, rg_q;
    logic [WIDE_W-1:0] res_w, lim_w;

    always_comb begin
        rg_d    = rg_q;
        rdata_o = '0;
        res_w   = '0;
        lim_w   = '0;
        for (int n = 0; n < NUM_FANS; n++) begin
            res_w = WIDE_W'(results_i[n]);
            lim_w = WIDE_W'(rg_q.limit[n]);
            if (idx_i == IDX_W'(CNT_IDX_BASE + 2*n)) begin
                rdata_o = res_w[WIDE_W-1:DATA_W];
                if (rd_i) rg_d.latch[n] = res_w[DATA_W-1:0];
            end
            if (idx_i == IDX_W'(CNT_IDX_BASE + 2*n + 1)) rdata_o = rg_q.latch[n];
            if (idx_i == IDX_W'(LIM_IDX_BASE + 2*n)) begin
                rdata_o = lim_w[WIDE_W-1:DATA_W];
                if (wr_i) rg_d.stage = wdata_i[STG_W-1:0];
            end
            if (idx_i == IDX_W'(LIM_IDX_BASE + 2*n + 1)) begin
                rdata_o = lim_w[DATA_W-1:0];
                if (wr_i) rg_d.limit[n] = {rg_q.stage, wdata_i};
            end
            if (idx_i == IDX_W'(CTRL_IDX_BASE + CTRL_STRIDE*n)) begin
                rdata_o = rg_q.ctrl[n];
                if (wr_i) rg_d.ctrl[n] = wdata_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rg_q       <= '0;
            rg_q.limit <= '1;
        end else begin
            rg_q <= rg_d;
        end
    end

    assign limits_o = rg_q.limit;

    generate
        for (genvar g = 0; g < NUM_FANS; g++) begin : g_en
            assign en_o[g] = ~rg_q.ctrl[g][OFF_BIT];
        end
    endgenerate
endmodule

// File: rtl/fan_tach_monitor.sv
module fan_tach_monitor
    import fan_tach_pkg::*;
#(
    parameter int NUM_FANS = 3,
    parameter int CNT_W    = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic [NUM_FANS-1:0] tach_in,
    input  logic [7:0]          reg_idx,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [7:0]          reg_wdata,
    output logic [7:0]          reg_rdata,
    output logic [NUM_FANS-1:0] fan_alarm
);
    logic [NUM_FANS-1:0][CNT_W-1:0] count_w;
    logic [NUM_FANS-1:0][CNT_W-1:0] limit_w;
    logic [NUM_FANS-1:0]            en_w;

    generate
        for (genvar g = 0; g < NUM_FANS; g++) begin : g_fan
            fan_tach_channel #(.CNT_W(CNT_W)) u_chan (
                .clk      (clk),
                .rst_n    (rst_n),
                .tick_i   (tick),
                .tach_i   (tach_in[g]),
                .en_i     (en_w[g]),
                .result_o (count_w[g])
            );
            assign fan_alarm[g] = en_w[g] & (count_w[g] > limit_w[g]);
        end
    endgenerate

    fan_tach_regs #(.NUM_FANS(NUM_FANS), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx_i     (reg_idx),
        .wr_i      (reg_wr),
        .rd_i      (reg_rd),
        .wdata_i   (reg_wdata),
        .results_i (count_w),
        .rdata_o   (reg_rdata),
        .limits_o  (limit_w),
        .en_o      (en_w)
    );
endmodule

// File: rtl/fan_tach_checker.sv
module fan_tach_checker
    import fan_tach_pkg::*;
#(
    parameter int NUM_FANS = 3,
    parameter int CNT_W    = 12
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [7:0]                     reg_idx,
    input logic                           reg_rd,
    input logic [7:0]                     reg_rdata,
    input logic [NUM_FANS-1:0]            fan_alarm,
    input logic [NUM_FANS-1:0][CNT_W-1:0] count_w,
    input logic [NUM_FANS-1:0][CNT_W-1:0] limit_w,
    input logic [NUM_FANS-1:0]            en_w
);
    generate
        for (genvar g = 0; g < NUM_FANS; g++) begin : g_chk
            localparam logic [7:0] HI = 8'(CNT_IDX_BASE + 2*g);
            localparam logic [7:0] LO = 8'(CNT_IDX_BASE + 2*g + 1);

            a_r7_off_no_alarm: assert property (@(posedge clk) disable iff (!rst_n)
                !en_w[g] |-> !fan_alarm[g]);

            a_r7_off_result_zero: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && !$past(en_w[g]) && !en_w[g]) |-> (count_w[g] == '0));

            a_r8_max_limit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
                (limit_w[g] == '1) |-> !fan_alarm[g]);

            a_r4_high_nibble_zero: assert property (@(posedge clk) disable iff (!rst_n)
                (reg_idx == HI) |-> (reg_rdata[7:4] == 4'h0));

            a_r5_coherent_pair: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(reg_rd) && $past(reg_idx) == HI
                 && reg_rd && reg_idx == LO)
                |-> (reg_rdata == $past(count_w[g][7:0])));
        end
    endgenerate
endmodule

bind fan_tach_monitor fan_tach_checker #(.NUM_FANS(NUM_FANS), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_idx   (reg_idx),
    .reg_rd    (reg_rd),
    .reg_rdata (reg_rdata),
    .fan_alarm (fan_alarm),
    .count_w   (count_w),
    .limit_w   (limit_w),
    .en_w      (en_w)
);

// File: tb/tb_fan_tach_monitor.sv
module tb_fan_tach_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int NF = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic [NF-1:0] tach = '0;
    logic [7:0]    idx = 8'h00;
    logic          wr = 1'b0;
    logic          rd = 1'b0;
    logic [7:0]    wdata = 8'h00;
    logic [7:0]    rdata;
    logic [NF-1:0] alarm;

    fan_tach_monitor dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .tach_in(tach),
        .reg_idx(idx), .reg_wr(wr), .reg_rd(rd), .reg_wdata(wdata),
        .reg_rdata(rdata), .fan_alarm(alarm)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int tests = 0, fails = 0, cyc = 0;
    int tick_every = 1;
    int tper[NF];
    int tph[NF];
    int last = 0;

    int m_run[NF], m_res[NF], m_prev[NF], m_lim[NF], m_ctrl[NF], m_latch[NF];
    int m_stage = 0;

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s cyc=%0d actual=%0d expected=%0d", tag, cyc, act, exp);
        end
    endtask

    function automatic int exp_rdata(input int i);
        for (int n = 0; n < NF; n++) begin
            if (i == 32 + 2*n) return m_res[n] >> 8;
            if (i == 33 + 2*n) return m_latch[n];
            if (i == 40 + 2*n) return m_lim[n] >> 8;
            if (i == 41 + 2*n) return m_lim[n] & 255;
            if (i == 96 + 16*n) return m_ctrl[n];
        end
        return 0;
    endfunction

    function automatic int exp_alarm(input int n);
        return ((m_ctrl[n] & 128) == 0 && m_res[n] > m_lim[n]) ? 1 : 0;
    endfunction

    task automatic model_step();
        int i;
        i = int'(idx);
        if (!rst_n) begin
            for (int n = 0; n < NF; n++) begin
                m_run[n] = 0; m_res[n] = 0; m_prev[n] = 0;
                m_lim[n] = 4095; m_ctrl[n] = 0; m_latch[n] = 0;
            end
            m_stage = 0;
        end else begin
            for (int n = 0; n < NF; n++)
                if (rd && i == 32 + 2*n) m_latch[n] = m_res[n] & 255;
            for (int n = 0; n < NF; n++) begin
                int edge_seen;
                edge_seen = (tach[n] && m_prev[n] == 0) ? 1 : 0;
                m_prev[n] = tach[n] ? 1 : 0;
                if ((m_ctrl[n] & 128) != 0) begin
                    m_run[n] = 0; m_res[n] = 0;
                end else if (edge_seen != 0) begin
                    m_res[n] = m_run[n]; m_run[n] = 0;
                end else begin
                    if (m_run[n] == 4095) m_res[n] = 4095;
                    if (tick && m_run[n] < 4095) m_run[n]++;
                end
            end
            if (wr)
                for (int n = 0; n < NF; n++) begin
                    if (i == 40 + 2*n) m_stage = int'(wdata) & 15;
                    if (i == 41 + 2*n) m_lim[n] = (m_stage << 8) | int'(wdata);
                    if (i == 96 + 16*n) m_ctrl[n] = int'(wdata);
                end
        end
    endtask

    // One clock: drive generators at the falling edge, compare before the rising edge
    task automatic step();
        tick = (tick_every > 0) && (cyc % tick_every == 0);
        for (int n = 0; n < NF; n++) begin
            if (tper[n] == 0) tach[n] = 1'b0;
            else begin
                tach[n] = (tph[n] < tper[n] / 2);
                tph[n] = (tph[n] + 1) % tper[n];
            end
        end
        #1;
        if (rst_n) begin
            check("R4 model rdata", int'(rdata), exp_rdata(int'(idx)));
            for (int n = 0; n < NF; n++)
                check("R8 model alarm", int'(alarm[n]), exp_alarm(n));
        end
        last = int'(rdata);
        @(posedge clk);
        model_step();
        cyc++;
        @(negedge clk);
    endtask

    task automatic idle(input int k);
        for (int j = 0; j < k; j++) step();
    endtask

    task automatic wr_reg(input int i, input int d);
        idx = 8'(i); wdata = 8'(d); wr = 1'b1;
        step();
        wr = 1'b0;
    endtask

    task automatic rd_reg(input int i, output int v);
        idx = 8'(i); rd = 1'b1;
        step();
        v = last;
        rd = 1'b0;
    endtask

    task automatic rd16(input int hi_idx, output int v);
        int h, l;
        rd_reg(hi_idx, h);
        rd_reg(hi_idx + 1, l);
        v = (h << 8) | l;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        tests++; fails++;
        $display("FAIL R2 watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        int v, v0, h, l;
        for (int n = 0; n < NF; n++) begin tper[n] = 0; tph[n] = 0; end
        @(negedge clk);
        idle(4);
        rst_n = 1'b1;

        // R1 reset state, and R5 latch empty before any high read
        rd_reg(8'h21, v); check("R1 R5 latch after reset", v, 0);
        rd_reg(8'h20, v); check("R1 result hi after reset", v, 0);
        rd_reg(8'h28, v); check("R1 limit hi after reset", v, 8'h0F);
        rd_reg(8'h29, v); check("R1 limit lo after reset", v, 8'hFF);
        rd_reg(8'h60, v); check("R1 control after reset", v, 0);
        check("R1 alarms after reset", int'(alarm), 0);

        // R2 capture with a tick on every cycle (edge cycle coincides with a tick)
        tick_every = 1; tper[0] = 50; tper[1] = 23;
        idle(200);
        rd16(8'h20, v); check("R2 fan0 period 50", v, 49);
        rd16(8'h22, v); check("R2 fan1 period 23", v, 22);

        // R2 slower timebase
        tick_every = 4; tper[0] = 100;
        idle(400);
        rd16(8'h20, v0); check("R2 slow tick count 24..25", (v0 == 24 || v0 == 25) ? 1 : 0, 1);

        // R5 latch holds across a change of the result
        rd_reg(8'h20, h);
        tper[0] = 60;
        idle(300);
        rd_reg(8'h21, l); check("R5 latch held", l, v0 & 255);
        rd16(8'h20, v); check("R5 fresh pair after change", (v == 14 || v == 15) ? 1 : 0, 1);

        // Coincidence: back-to-back pairs while a fast fan captures
        tick_every = 1; tper[0] = 7;
        idle(30);
        for (int k = 0; k < 20; k++) begin
            rd16(8'h20, v); check("R5 coherent pair fast fan", v, 6);
        end

        // R3 saturation of the never-toggling fan 2; R8 max limit is quiet
        idle(4200);
        rd16(8'h24, v); check("R3 stopped fan saturates", v, 4095);
        check("R8 limit 0xFFF never alarms", int'(alarm[2]), 0);

        // R6 staging of the high byte
        wr_reg(8'h2C, 8'h03);
        rd_reg(8'h2C, v); check("R6 hi write alone no effect", v, 8'h0F);
        wr_reg(8'h2D, 8'hE8);
        rd16(8'h2C, v); check("R6 limit committed", v, 1000);
        check("R8 slow fan alarms", int'(alarm[2]), 1);
        wr_reg(8'h2A, 8'hF0);
        wr_reg(8'h2B, 8'h10);
        rd_reg(8'h2A, v); check("R6 upper nibble dropped", v, 0);
        check("R8 fan1 above limit 16", int'(alarm[1]), 1);

        // R8 boundary: equal does not alarm
        wr_reg(8'h2A, 8'h00); wr_reg(8'h2B, 22);
        check("R8 equal to limit quiet", int'(alarm[1]), 0);
        wr_reg(8'h2B, 21);
        check("R8 one above limit", int'(alarm[1]), 1);

        // R7 disable fan 1
        wr_reg(8'h70, 8'h80);
        idle(5);
        rd16(8'h22, v); check("R7 disabled result zero", v, 0);
        check("R7 disabled no alarm", int'(alarm[1]), 0);
        rd_reg(8'h70, v); check("R7 control readback", v, 8'h80);
        wr_reg(8'h70, 8'h00);
        idle(100);
        rd16(8'h22, v); check("R7 re-enabled fan measures", v, 22);

        // R9 ignored writes and unmapped reads
        wr_reg(8'h20, 8'h55);
        rd_reg(8'h20, v); check("R9 result hi not writable", v, 0);
        wr_reg(8'h30, 8'hAA);
        rd_reg(8'h30, v); check("R9 unmapped reads zero", v, 0);
        rd_reg(8'h61, v); check("R9 gap next to control reads zero", v, 0);
        rd16(8'h28, v); check("R9 fan0 limit untouched", v, 4095);

        idle(10);
        finish_run();
    end
endmodule